// File: doc/BRIEF.md
# Two-Rail Line Jitter Smoother

This block takes a recovered line clock that carries jitter, together with its positive and negative data rails, and sends the same bit stream out again on a clean clock made inside the block. The input clock, after it is synchronised into the master domain, writes each bit pair into a circular store. A divider running at one quarter of the master clock reads the pairs back out at an even rate. The master clock is expected to run close to four times the line rate.

When the amount of data in the store comes near full or near empty, the divider moves to a fractional ratio for a while, either 3½ or 4½. The read rate then follows the short-term input rate and no bits are lost. A limit flag is high for every output period spent at a fractional ratio. A bypass input routes the synchronised line clock and rails straight to the outputs. A synchronous reset puts the read position half a store behind the write position. The depth select input may only change while reset is asserted.

Top module: `line_jitter_smoother`

## Requirements
- R1: Every store entry carries both rail bits, and the positive and negative output rails reproduce their own input rails independently, in the order the bits arrived.
- R2: Depth select high gives a 32-entry store and low gives a 128-entry store. After reset the first valid output bit is the first input bit, delayed by half the selected depth in output periods.
- R3: Each rising edge of the line clock stores exactly one bit pair, whatever its high time (one master cycle or more) and whatever its period (3 to 5 master cycles).
- R4: While the fill stays within the margins, the output clock period is exactly 4 master cycles.
- R5: While the fill stays within the margins (at least 4 and at most depth minus 4), the limit output stays low.
- R6: When the fill exceeds depth minus 4, the output periods alternate between 3 and 4 master cycles and the limit output goes high. It falls again once the fill is back within the margins, and no bit is lost.
- R7: When the fill drops below 4, the output periods alternate between 4 and 5 master cycles and the limit output goes high. It falls again once the fill is back within the margins, and no bit is lost.
- R8: With bypass high, out_clk, out_p and out_n follow line_clk, line_p and line_n after the synchroniser delay, and limit is low.
- R9: During reset and in the cycle after it, out_clk, out_p, out_n and limit are all 0. Each reset sets the pointers back up so that the R2 latency holds again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_4x | input | 1 | Master clock at four times the line rate |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Recovered line clock with jitter |
| line_p | input | 1 | Positive data rail |
| line_n | input | 1 | Negative data rail |
| short_sel | input | 1 | 1 selects a 32-entry store, 0 selects 128 entries |
| bypass | input | 1 | 1 routes the synchronised inputs straight to the outputs |
| out_clk | output | 1 | Regenerated line clock |
| out_p | output | 1 | Smoothed positive rail |
| out_n | output | 1 | Smoothed negative rail |
| limit | output | 1 | High while a fractional divide ratio is in use |

## Verification
A wrong pointer or fill value inside the store shows at the ports as a shift or a gap in the bit sequence on out_p and out_n. Because the stream is a computed pattern, the first misplaced bit is caught at the output rising edge where it appears, one store latency after the write. A fault in the rate logic shows within a single output period as a spacing between out_clk rises other than 4, or, in the sweeps that push the fill toward either end, as a limit flag that never rises, never falls, or comes with the wrong pair of period lengths. Bypass and reset are checked directly at the pins within a few cycles.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

  typedef enum logic [1:0] {
    RATE_NOMINAL = 2'd0,
    RATE_FAST    = 2'd1,
    RATE_SLOW    = 2'd2
  } rate_mode_t;

  // Output period in master cycles for a mode and the alternation phase.
  function automatic logic [2:0] period_for(rate_mode_t m, logic alt);
    case (m)
      RATE_FAST: return alt ? 3'd4 : 3'd3;
      RATE_SLOW: return alt ? 3'd5 : 3'd4;
      default:   return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/jsm_line_sync.sv
module jsm_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_clk,
  input  logic line_p,
  input  logic line_n,
  output logic s_clk,
  output logic s_p,
  output logic s_n,
  output logic wr_en
);
  logic [SYNC_STAGES-1:0] c_q, p_q, n_q;
  logic c_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q    <= '0;
      p_q    <= '0;
      n_q    <= '0;
      c_last <= 1'b0;
    end else begin
      c_q    <= {c_q[SYNC_STAGES-2:0], line_clk};
      p_q    <= {p_q[SYNC_STAGES-2:0], line_p};
      n_q    <= {n_q[SYNC_STAGES-2:0], line_n};
      c_last <= c_q[SYNC_STAGES-1];
    end
  end

  assign s_clk = c_q[SYNC_STAGES-1];
  assign s_p   = p_q[SYNC_STAGES-1];
  assign s_n   = n_q[SYNC_STAGES-1];
  assign wr_en = s_clk & ~c_last;

  // R3: one line edge yields a single-cycle write strobe
  p_one_write_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

endmodule

// File: rtl/jsm_store.sv
module jsm_store #(
  parameter int DEPTH_LONG  = 128,
  parameter int DEPTH_SHORT = 32,
  localparam int AW = $clog2(DEPTH_LONG)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] depth,
  input  logic        wr_en,
  input  logic [1:0]  wr_data,
  input  logic        rd_req,
  output logic [1:0]  rd_data,
  output logic [AW:0] fill
);
  logic [1:0]    mem [DEPTH_LONG];
  logic [AW-1:0] wr_ptr, rd_ptr, mask;
  logic          rd_ok, wr_ok;

  assign mask  = AW'(depth - 1'b1);
  assign rd_ok = rd_req && (fill != '0);
  assign wr_ok = wr_en && ((fill != depth) || rd_ok);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 2'b00;
    else if (rd_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= AW'(depth >> 1);
      rd_ptr <= '0;
      fill   <= depth >> 1;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr + 1'b1) & mask;
      if (rd_ok) rd_ptr <= (rd_ptr + 1'b1) & mask;
      fill <= fill + {{AW{1'b0}}, wr_ok} - {{AW{1'b0}}, rd_ok};
    end
  end

  // R6: the rate logic keeps the fill inside the selected depth
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fill <= depth);

endmodule

// File: rtl/jsm_rate_ctl.sv
module jsm_rate_ctl
  import jsm_pkg::*;
#(
  parameter int AW     = 7,
  parameter int MARGIN = 4,
  parameter int HIGH_CYC = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] fill,
  input  logic [AW:0] depth,
  output logic        tick,
  output logic        gen_clk,
  output logic        lim_q
);
  logic [2:0] cnt, period;
  logic       alt;
  rate_mode_t mode_q, mode_n;

  always_comb begin
    if (fill > (depth - (AW+1)'(MARGIN)))  mode_n = RATE_FAST;
    else if (fill < (AW+1)'(MARGIN))        mode_n = RATE_SLOW;
    else                                    mode_n = RATE_NOMINAL;
  end

  assign tick    = (cnt == period - 3'd1);
  assign gen_clk = (cnt < 3'(HIGH_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      period <= 3'd4;
      alt    <= 1'b0;
      mode_q <= RATE_NOMINAL;
      lim_q  <= 1'b0;
    end else if (tick) begin
      cnt    <= '0;
      alt    <= ~alt;
      mode_q <= mode_n;
      period <= period_for(mode_n, ~alt);
      lim_q  <= (mode_n != RATE_NOMINAL);
    end else begin
      cnt <= cnt + 3'd1;
    end
  end

  // R4: a nominal period ends after its fourth cycle
  p_nominal_len_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_q == RATE_NOMINAL) |-> (cnt == 3'd3));

  // R6 and R7: fractional periods span 3 to 5 cycles only
  p_frac_len_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_q != RATE_NOMINAL) |-> (cnt >= 3'd2 && cnt <= 3'd4));

endmodule

// File: rtl/line_jitter_smoother.sv
module line_jitter_smoother #(
  parameter int DEPTH_LONG  = 128,
  parameter int DEPTH_SHORT = 32,
  parameter int MARGIN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_4x,
  input  logic rst,
  input  logic line_clk,
  input  logic line_p,
  input  logic line_n,
  input  logic short_sel,
  input  logic bypass,
  output logic out_clk,
  output logic out_p,
  output logic out_n,
  output logic limit
);
  localparam int AW = $clog2(DEPTH_LONG);

  logic [AW:0] depth, fill;
  logic        s_clk, s_p, s_n, wr_en;
  logic        tick, gen_clk, lim_q;
  logic [1:0]  rd_data;

  assign depth = short_sel ? (AW+1)'(DEPTH_SHORT) : (AW+1)'(DEPTH_LONG);

  jsm_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_4x), .rst(rst), .line_clk(line_clk), .line_p(line_p),
    .line_n(line_n), .s_clk(s_clk), .s_p(s_p), .s_n(s_n), .wr_en(wr_en)
  );

  jsm_store #(.DEPTH_LONG(DEPTH_LONG), .DEPTH_SHORT(DEPTH_SHORT)) u_store (
    .clk(clk_4x), .rst(rst), .depth(depth), .wr_en(wr_en),
    .wr_data({s_p, s_n}), .rd_req(tick), .rd_data(rd_data), .fill(fill)
  );

  jsm_rate_ctl #(.AW(AW), .MARGIN(MARGIN)) u_rate (
    .clk(clk_4x), .rst(rst), .fill(fill), .depth(depth),
    .tick(tick), .gen_clk(gen_clk), .lim_q(lim_q)
  );

  always_ff @(posedge clk_4x) begin
    if (rst) begin
      out_clk <= 1'b0;
      out_p   <= 1'b0;
      out_n   <= 1'b0;
      limit   <= 1'b0;
    end else if (bypass) begin
      out_clk <= s_clk;
      out_p   <= s_p;
      out_n   <= s_n;
      limit   <= 1'b0;
    end else begin
      out_clk <= gen_clk;
      out_p   <= rd_data[1];
      out_n   <= rd_data[0];
      limit   <= lim_q;
    end
  end

  // R5: a period decided inside the margins shows no limit
  p_margin_quiet_r5: assert property (@(posedge clk_4x) disable iff (rst)
    (tick && !bypass && fill >= (AW+1)'(MARGIN) &&
     fill <= depth - (AW+1)'(MARGIN)) |-> ##2 (!limit || rst));

  // R8: bypass forwards the synchronised line signals
  p_bypass_r8: assert property (@(posedge clk_4x) disable iff (rst)
    $past(bypass) |-> (out_clk == $past(s_clk) && out_p == $past(s_p) &&
                       out_n == $past(s_n) && !limit));

  // R9: outputs are cleared by reset
  p_reset_clear_r9: assert property (@(posedge clk_4x)
    $past(rst) |-> (!out_clk && !out_p && !out_n && !limit));

endmodule

// File: tb/line_jitter_smoother_test.sv
module line_jitter_smoother_test;
  logic clk = 1'b0, rst = 1'b1;
  logic line_clk = 1'b0, line_p = 1'b0, line_n = 1'b0;
  logic short_sel = 1'b1, bypass = 1'b0;
  logic out_clk, out_p, out_n, limit;

  always #2 clk = ~clk;

  line_jitter_smoother uut (
    .clk_4x(clk), .rst(rst), .line_clk(line_clk), .line_p(line_p),
    .line_n(line_n), .short_sel(short_sel), .bypass(bypass),
    .out_clk(out_clk), .out_p(out_p), .out_n(out_n), .limit(limit)
  );

  int n_cmp = 0, n_bad = 0;
  int cur_depth = 32, wr_count = 0, rise_idx = 0, since = 0;
  int per_min = 99, per_max = 0;
  bit mon_en = 0, prev_oc = 0, prev_lim = 0, lim_seen = 0, lim_fell = 0;
  string data_tag = "R1 R2";

  function automatic bit exp_p(int i);
    return ((i * 5 + (i >> 2)) % 3) == 0;
  endfunction
  function automatic bit exp_n(int i);
    return ((i ^ (i >> 1)) & 1) == 1;
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Monitor: data order and output period spacing
  always @(negedge clk) begin
    if (mon_en) begin
      since++;
      if (out_clk && !prev_oc) begin
        if (rise_idx >= 2) begin
          if (since < per_min) per_min = since;
          if (since > per_max) per_max = since;
        end
        begin
          int j;
          j = rise_idx - 1 - cur_depth / 2;
          if (j >= 0 && j < wr_count - 4) begin
            n_cmp++;
            if (out_p !== exp_p(j) || out_n !== exp_n(j)) begin
              n_bad++;
              $display("FAIL %s bit %0d: got %b%b expected %b%b", data_tag, j,
                       out_p, out_n, exp_p(j), exp_n(j));
            end
          end
        end
        rise_idx++;
        since = 0;
      end
      if (limit && !prev_lim) lim_seen = 1;
      if (!limit && prev_lim) lim_fell = 1;
    end
    prev_oc  = out_clk;
    prev_lim = limit;
  end

  task automatic do_reset(input bit short, input bit byp);
    @(negedge clk);
    mon_en = 0; rst = 1; short_sel = short; bypass = byp;
    line_clk = 0; line_p = 0; line_n = 0;
    cur_depth = short ? 32 : 128;
    repeat (4) @(negedge clk);
    // R9: reset state at the pins
    check({out_clk, out_p, out_n, limit} == 4'b0000, "R9 reset outputs",
          {out_clk, out_p, out_n, limit}, 0);
    wr_count = 0; rise_idx = 0; since = 0; per_min = 99; per_max = 0;
    lim_seen = 0; lim_fell = 0;
    rst = 0;
    mon_en = !byp;
  endtask

  task automatic send(input int hi, input int lo);
    line_clk = 1; line_p = exp_p(wr_count); line_n = exp_n(wr_count);
    wr_count++;
    repeat (hi) @(negedge clk);
    line_clk = 0;
    repeat (lo) @(negedge clk);
  endtask

  // kind 0 nominal, 1 varying duty and period, 2 fast input, 3 slow input
  task automatic run_stream(input int n, input int kind);
    for (int i = 0; i < n; i++) begin
      case (kind)
        1: case (i % 4) 0: send(1, 2); 1: send(3, 2); 2: send(2, 2); default: send(1, 3); endcase
        2: if (i % 4 == 0) send(2, 1); else send(2, 2);
        3: if (i % 3 == 2) send(3, 2); else send(2, 2);
        default: send(2, 2);
      endcase
    end
    mon_en = 0;
  endtask

  initial begin
    // 32-entry store, steady input
    data_tag = "R1 R2";
    do_reset(1, 0);
    run_stream(300, 0);
    check(per_min == 4 && per_max == 4, "R4 period 32", per_max, 4);
    check(!lim_seen, "R5 limit low 32", lim_seen, 0);

    // 128-entry store after a fresh reset
    data_tag = "R2 R9";
    do_reset(0, 0);
    run_stream(400, 0);
    check(per_min == 4 && per_max == 4, "R4 period 128", per_min, 4);
    check(!lim_seen, "R5 limit low 128", lim_seen, 0);

    // varying high time and period, same average rate
    data_tag = "R3";
    do_reset(1, 0);
    run_stream(400, 1);
    check(per_min == 4 && per_max == 4, "R4 period under jitter", per_max, 4);
    check(!lim_seen, "R5 limit low under jitter", lim_seen, 0);

    // input faster than nominal: fill reaches the upper margin
    data_tag = "R6";
    do_reset(1, 0);
    run_stream(1600, 2);
    check(lim_seen, "R6 limit rose", lim_seen, 1);
    check(lim_fell, "R6 limit fell", lim_fell, 1);
    check(per_min == 3, "R6 shortest period", per_min, 3);
    check(per_max == 4, "R6 longest period", per_max, 4);

    // input slower than nominal: fill reaches the lower margin
    data_tag = "R7";
    do_reset(1, 0);
    run_stream(1600, 3);
    check(lim_seen, "R7 limit rose", lim_seen, 1);
    check(lim_fell, "R7 limit fell", lim_fell, 1);
    check(per_min == 4, "R7 shortest period", per_min, 4);
    check(per_max == 5, "R7 longest period", per_max, 5);

    // bypass: every input combination reaches the pins
    do_reset(1, 1);
    for (int v = 0; v < 8; v++) begin
      line_clk = v[2]; line_p = v[1]; line_n = v[0];
      repeat (5) @(negedge clk);
      check({out_clk, out_p, out_n} == 3'(v), "R8 bypass", {out_clk, out_p, out_n}, v);
      check(!limit, "R8 limit in bypass", limit, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule